// File: doc/BRIEF.md
# Single-Cycle RV32 Subset Processor Core

This core runs a small subset of the RV32I integer instructions. Each instruction finishes in one clock period. In that period the core fetches the word at the program counter, decodes it, reads two source registers, computes in the ALU, accesses data memory, and selects the next program counter. The program counter, the register file and the data memory all change together on the rising clock edge. The subset is register-register add and subtract, word load, word store, branch-if-equal and jump-and-link.

Instruction memory and data memory are small word arrays inside the core. A load port writes words into either array. It is meant to be used while the core is held in reset, so that a program and its data are in place before execution starts. The core drives a commit trace for the instruction currently at the program counter, without a register stage: register write enable, destination, write value, store enable, store address and store data. Together with the program counter, this trace makes every architectural effect visible at the ports.

Top module: `sc_core`

## Requirements
- R1: While `rst_n` is low at a rising edge, the program counter becomes 0. In that state `wb_en` and `st_en` are 0, so no register or data-memory write takes place. The register file is not cleared.
- R2: Register-register instructions (opcode 0110011, funct3 000) write rs1+rs2 into rd when funct7 is 0000000, and rs1−rs2 when funct7 is 0100000.
- R3: Register 0 always reads as zero. An instruction whose destination is register 0 leaves `wb_en` low, and no register changes.
- R4: A word load (opcode 0000011, funct3 010) writes into rd the data word at byte address rs1 + sign-extended I immediate (bits 31:20).
- R5: A word store (opcode 0100011, funct3 010) writes rs2 to byte address rs1 + sign-extended S immediate (bits 31:25 and 11:7). It raises `st_en` and leaves `wb_en` low.
- R6: Branch-if-equal (opcode 1100011, funct3 000) sets the next PC to PC + B offset when rs1 equals rs2, and to PC+4 otherwise. The B offset has an implicit zero bit 0. Neither case writes a register.
- R7: Jump-and-link (opcode 1101111) sets the next PC to PC + J offset, which has an implicit zero bit 0, and writes PC+4 into rd.
- R8: Any other opcode, or an unsupported funct3/funct7 combination, acts as a no-operation. It writes nothing and advances the PC by 4.
- R9: Every instruction that neither jumps nor takes a branch advances the PC by exactly 4.
- R10: A load-port write stores `ld_data` into word `ld_addr` of instruction memory when `ld_sel` is 0, and of data memory when `ld_sel` is 1. Memories are indexed by byte-address bits above bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_en | input | 1 | Load-port write strobe |
| ld_sel | input | 1 | Load target: 0 instruction memory, 1 data memory |
| ld_addr | input | MEM_AW | Word index written by the load port |
| ld_data | input | XLEN | Word written by the load port |
| pc_out | output | XLEN | Current program counter |
| wb_en | output | 1 | Current instruction writes a register |
| wb_rd | output | 5 | Destination register of the current instruction |
| wb_data | output | XLEN | Value written to the destination register |
| st_en | output | 1 | Current instruction writes data memory |
| st_addr | output | XLEN | Byte address of the store |
| st_data | output | XLEN | Word stored |

## Verification
The commit-trace outputs belong to the instruction at the current PC and are valid in the same cycle, with no register delay. The new PC, and the register or memory value the instruction writes, appear after the next rising edge. A register write is therefore seen when a later instruction reads that register. The bench drives inputs and samples outputs on the falling edge. At each falling edge it compares the trace and `pc_out` with a behavioural model, and then steps the model once for the rising edge that follows. Reset takes effect on the first rising edge with `rst_n` low, so the PC is checked one falling edge later.

// File: rtl/sc_pkg.sv
// Package: shared opcodes, control word and selector enums for the
// single-cycle core. Assumes XLEN of 32 and RV32I field positions.
package sc_pkg;

    localparam logic [6:0] OPC_RTYPE  = 7'b0110011;
    localparam logic [6:0] OPC_LOAD   = 7'b0000011;
    localparam logic [6:0] OPC_STORE  = 7'b0100011;
    localparam logic [6:0] OPC_BRANCH = 7'b1100011;
    localparam logic [6:0] OPC_JAL    = 7'b1101111;

    typedef enum logic [1:0] {
        ALUOP_ADD   = 2'b00,
        ALUOP_SUB   = 2'b01,
        ALUOP_FUNCT = 2'b10
    } aluop_e;

    typedef enum logic [1:0] {
        IMM_I = 2'b00,
        IMM_S = 2'b01,
        IMM_B = 2'b10,
        IMM_J = 2'b11
    } immsel_e;

    typedef enum logic [1:0] {
        WB_ALU  = 2'b00,
        WB_MEM  = 2'b01,
        WB_LINK = 2'b10
    } wbsel_e;

    typedef enum logic [1:0] {
        NPC_SEQ    = 2'b00,
        NPC_BRANCH = 2'b01,
        NPC_JUMP   = 2'b10
    } npcsel_e;

    typedef struct packed {
        logic    reg_write;
        logic    mem_write;
        wbsel_e  wb_sel;
        logic    alu_src;
        logic    branch;
        logic    jump;
        aluop_e  alu_op;
        immsel_e imm_sel;
    } ctrl_t;

endpackage

// File: rtl/sc_decode.sv
// Module: main decoder. Turns an instruction word into the control word.
// Assumes unsupported encodings must produce an all-inactive control word.
module sc_decode
    import sc_pkg::*;
(
    input  logic [31:0] instr,
    output ctrl_t       ctl
);

    logic [6:0] opc;
    logic [2:0] f3;
    logic [6:0] f7;

    assign opc = instr[6:0];
    assign f3  = instr[14:12];
    assign f7  = instr[31:25];

    // Control word per supported opcode; default is a no-operation.
    always_comb begin
        ctl = '{reg_write: 1'b0, mem_write: 1'b0, wb_sel: WB_ALU,
                alu_src: 1'b0, branch: 1'b0, jump: 1'b0,
                alu_op: ALUOP_ADD, imm_sel: IMM_I};
        case (opc)
            OPC_RTYPE: if (f3 == 3'b000 && (f7 == 7'b0000000 || f7 == 7'b0100000)) begin
                ctl.reg_write = 1'b1;
                ctl.alu_op    = ALUOP_FUNCT;
            end
            OPC_LOAD: if (f3 == 3'b010) begin
                ctl.reg_write = 1'b1;
                ctl.alu_src   = 1'b1;
                ctl.wb_sel    = WB_MEM;
            end
            OPC_STORE: if (f3 == 3'b010) begin
                ctl.mem_write = 1'b1;
                ctl.alu_src   = 1'b1;
                ctl.imm_sel   = IMM_S;
            end
            OPC_BRANCH: if (f3 == 3'b000) begin
                ctl.branch  = 1'b1;
                ctl.alu_op  = ALUOP_SUB;
                ctl.imm_sel = IMM_B;
            end
            OPC_JAL: begin
                ctl.reg_write = 1'b1;
                ctl.jump      = 1'b1;
                ctl.wb_sel    = WB_LINK;
                ctl.imm_sel   = IMM_J;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/sc_immgen.sv
// Module: immediate extractor. Builds a sign-extended immediate in the
// format chosen by the decoder. B and J offsets carry a zero bit 0.
module sc_immgen
    import sc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [31:0]     instr,
    input  immsel_e         sel,
    output logic [XLEN-1:0] imm
);

    logic [31:0] imm32;

    // Field gathering per format.
    always_comb begin
        case (sel)
            IMM_I:   imm32 = {{20{instr[31]}}, instr[31:20]};
            IMM_S:   imm32 = {{20{instr[31]}}, instr[31:25], instr[11:7]};
            IMM_B:   imm32 = {{19{instr[31]}}, instr[31], instr[7],
                              instr[30:25], instr[11:8], 1'b0};
            default: imm32 = {{11{instr[31]}}, instr[31], instr[19:12],
                              instr[20], instr[30:21], 1'b0};
        endcase
    end

    assign imm = XLEN'(signed'(imm32));

endmodule

// File: rtl/sc_regfile.sv
// Module: register file with two combinational read ports and one
// synchronous write port. Entry 0 reads as zero and ignores writes.
module sc_regfile #(
    parameter int XLEN = 32,
    parameter int NREG = 32,
    localparam int RAW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            we,
    input  logic [RAW-1:0]  wa,
    input  logic [XLEN-1:0] wd,
    input  logic [RAW-1:0]  ra1,
    input  logic [RAW-1:0]  ra2,
    output logic [XLEN-1:0] rd1,
    output logic [XLEN-1:0] rd2
);

    logic [XLEN-1:0] regs [1:NREG-1];

    // Register write; writes to entry 0 are dropped.
    always_ff @(posedge clk) begin
        if (we && wa != '0) regs[wa] <= wd;
    end

    assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
    assign rd2 = (ra2 == '0) ? '0 : regs[ra2];

endmodule

// File: rtl/sc_alu.sv
// Module: ALU with its local control. Supports add and subtract.
// The zero flag serves the branch compare.
module sc_alu
    import sc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  aluop_e          op,
    input  logic            sub_bit,
    output logic [XLEN-1:0] res,
    output logic            zero
);

    logic do_sub;

    // ALU control: FUNCT category looks at funct7 bit 30.
    always_comb begin
        case (op)
            ALUOP_SUB:   do_sub = 1'b1;
            ALUOP_FUNCT: do_sub = sub_bit;
            default:     do_sub = 1'b0;
        endcase
    end

    assign res  = do_sub ? (a - b) : (a + b);
    assign zero = (res == '0);

endmodule

// File: rtl/sc_wordmem.sv
// Module: word-wide memory with one combinational read port and one
// synchronous write port. Callers pass word indices, not byte addresses.
module sc_wordmem #(
    parameter int XLEN  = 32,
    parameter int WORDS = 64,
    localparam int AW = $clog2(WORDS)
) (
    input  logic            clk,
    input  logic            we,
    input  logic [AW-1:0]   wa,
    input  logic [XLEN-1:0] wd,
    input  logic [AW-1:0]   ra,
    output logic [XLEN-1:0] rd
);

    logic [XLEN-1:0] mem [WORDS];

    // Word write.
    always_ff @(posedge clk) begin
        if (we) mem[wa] <= wd;
    end

    assign rd = mem[ra];

endmodule

// File: rtl/sc_core.sv
// Module: top of the single-cycle core. Connects PC, instruction memory,
// decoder, register file, immediate unit, ALU, data memory and the
// next-PC selection. Assumes the load port is used while rst_n is low;
// a load-port write to data memory overrides a concurrent store.
module sc_core
    import sc_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter int MEM_WORDS = 64,
    localparam int MEM_AW   = $clog2(MEM_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic              ld_sel,
    input  logic [MEM_AW-1:0] ld_addr,
    input  logic [XLEN-1:0]   ld_data,
    output logic [XLEN-1:0]   pc_out,
    output logic              wb_en,
    output logic [4:0]        wb_rd,
    output logic [XLEN-1:0]   wb_data,
    output logic              st_en,
    output logic [XLEN-1:0]   st_addr,
    output logic [XLEN-1:0]   st_data
);

    logic [XLEN-1:0]   pc_q, pc_nxt, pc_seq, pc_tgt;
    logic [31:0]       instr;
    ctrl_t             ctl;
    logic [XLEN-1:0]   imm, rs1_val, rs2_val, alu_b, alu_res, dmem_rd;
    logic              alu_zero;
    npcsel_e           npc_sel;
    logic              dm_we;
    logic [MEM_AW-1:0] dm_wa;
    logic [XLEN-1:0]   dm_wd;

    // Program counter register.
    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_nxt;
    end

    sc_wordmem #(.XLEN(XLEN), .WORDS(MEM_WORDS)) u_imem (
        .clk (clk),
        .we  (ld_en && !ld_sel),
        .wa  (ld_addr),
        .wd  (ld_data),
        .ra  (pc_q[MEM_AW+1:2]),
        .rd  (instr)
    );

    sc_decode u_dec (
        .instr (instr),
        .ctl   (ctl)
    );

    sc_immgen #(.XLEN(XLEN)) u_imm (
        .instr (instr),
        .sel   (ctl.imm_sel),
        .imm   (imm)
    );

    sc_regfile #(.XLEN(XLEN), .NREG(32)) u_rf (
        .clk (clk),
        .we  (wb_en),
        .wa  (instr[11:7]),
        .wd  (wb_data),
        .ra1 (instr[19:15]),
        .ra2 (instr[24:20]),
        .rd1 (rs1_val),
        .rd2 (rs2_val)
    );

    assign alu_b = ctl.alu_src ? imm : rs2_val;

    sc_alu #(.XLEN(XLEN)) u_alu (
        .a       (rs1_val),
        .b       (alu_b),
        .op      (ctl.alu_op),
        .sub_bit (instr[30]),
        .res     (alu_res),
        .zero    (alu_zero)
    );

    // Data-memory write port: load port has priority over the core.
    always_comb begin
        if (ld_en && ld_sel) begin
            dm_we = 1'b1;
            dm_wa = ld_addr;
            dm_wd = ld_data;
        end else begin
            dm_we = st_en;
            dm_wa = alu_res[MEM_AW+1:2];
            dm_wd = rs2_val;
        end
    end

    sc_wordmem #(.XLEN(XLEN), .WORDS(MEM_WORDS)) u_dmem (
        .clk (clk),
        .we  (dm_we),
        .wa  (dm_wa),
        .wd  (dm_wd),
        .ra  (alu_res[MEM_AW+1:2]),
        .rd  (dmem_rd)
    );

    // Separate sequential and target adders.
    assign pc_seq = pc_q + XLEN'(4);
    assign pc_tgt = pc_q + imm;

    // Write-back source selection.
    always_comb begin
        case (ctl.wb_sel)
            WB_MEM:  wb_data = dmem_rd;
            WB_LINK: wb_data = pc_seq;
            default: wb_data = alu_res;
        endcase
    end

    // Three-way next-PC choice.
    always_comb begin
        if (ctl.jump)                   npc_sel = NPC_JUMP;
        else if (ctl.branch && alu_zero) npc_sel = NPC_BRANCH;
        else                            npc_sel = NPC_SEQ;
        case (npc_sel)
            NPC_BRANCH, NPC_JUMP: pc_nxt = pc_tgt;
            default:              pc_nxt = pc_seq;
        endcase
    end

    assign wb_en   = rst_n && ctl.reg_write && (instr[11:7] != 5'd0);
    assign wb_rd   = instr[11:7];
    assign st_en   = rst_n && ctl.mem_write;
    assign st_addr = alu_res;
    assign st_data = rs2_val;
    assign pc_out  = pc_q;

endmodule

// File: rtl/sc_core_chk.sv
// Module: property checker for sc_core, attached by bind. Observes PC,
// commit trace and selected decoder/ALU outputs.
module sc_core_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic [XLEN-1:0] pc,
    input logic            wb_en,
    input logic [4:0]      wb_rd,
    input logic [XLEN-1:0] wb_data,
    input logic            st_en,
    input logic            is_branch,
    input logic            is_jump,
    input logic            alu_zero,
    input logic [XLEN-1:0] imm
);

    // R1: a reset edge leaves the PC at zero.
    a_r1_reset_pc: assert property (@(posedge clk) !rst_n |=> pc == '0);

    // R1: no commits while in reset.
    a_r1_no_commit: assert property (@(posedge clk) !rst_n |-> !wb_en && !st_en);

    // R3: register 0 is never the target of a performed write.
    a_r3_x0_untouched: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> wb_rd != 5'd0);

    // R5: a store never writes a register.
    a_r5_store_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
        st_en |-> !wb_en);

    // R6: a taken branch lands on PC + offset.
    a_r6_branch_target: assert property (@(posedge clk) disable iff (!rst_n)
        is_branch && alu_zero |=> pc == $past(pc) + $past(imm));

    // R7: jump-and-link writes the return address and lands on the target.
    a_r7_link_value: assert property (@(posedge clk) disable iff (!rst_n)
        is_jump && wb_en |-> wb_data == pc + XLEN'(4));
    a_r7_jump_target: assert property (@(posedge clk) disable iff (!rst_n)
        is_jump |=> pc == $past(pc) + $past(imm));

    // R9: no jump and no taken branch means a step of four.
    a_r9_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
        !is_jump && !(is_branch && alu_zero) |=> pc == $past(pc) + XLEN'(4));

endmodule

bind sc_core sc_core_chk #(.XLEN(XLEN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pc        (pc_out),
    .wb_en     (wb_en),
    .wb_rd     (wb_rd),
    .wb_data   (wb_data),
    .st_en     (st_en),
    .is_branch (ctl.branch),
    .is_jump   (ctl.jump),
    .alu_zero  (alu_zero),
    .imm       (imm)
);

// File: tb/tb_sc_core.sv
// Bench: loads a program under reset, then compares the core with a
// behavioural instruction-level model at every falling edge.
module tb_sc_core;

    localparam int XLEN   = 32;
    localparam int WORDS  = 64;
    localparam int AW     = $clog2(WORDS);
    localparam int NCYC   = 70;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            ld_en = 1'b0;
    logic            ld_sel = 1'b0;
    logic [AW-1:0]   ld_addr = '0;
    logic [XLEN-1:0] ld_data = '0;
    logic [XLEN-1:0] pc_out, wb_data, st_addr, st_data;
    logic            wb_en, st_en;
    logic [4:0]      wb_rd;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // Behavioural model state.
    logic [31:0] m_imem [WORDS];
    logic [31:0] m_dmem [WORDS];
    logic [31:0] m_reg  [32];
    logic [31:0] m_pc;

    always #2.5 clk = ~clk;

    sc_core #(.XLEN(XLEN), .MEM_WORDS(WORDS)) dut (
        .clk (clk), .rst_n (rst_n), .ld_en (ld_en), .ld_sel (ld_sel),
        .ld_addr (ld_addr), .ld_data (ld_data), .pc_out (pc_out),
        .wb_en (wb_en), .wb_rd (wb_rd), .wb_data (wb_data),
        .st_en (st_en), .st_addr (st_addr), .st_data (st_data)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] enc_r(input logic [6:0] f7, input int rd, input int rs1, input int rs2);
        return {f7, 5'(rs2), 5'(rs1), 3'b000, 5'(rd), 7'b0110011};
    endfunction
    function automatic logic [31:0] enc_lw(input int rd, input int rs1, input int imm);
        logic [11:0] i = 12'(imm);
        return {i, 5'(rs1), 3'b010, 5'(rd), 7'b0000011};
    endfunction
    function automatic logic [31:0] enc_sw(input int rs2, input int rs1, input int imm);
        logic [11:0] i = 12'(imm);
        return {i[11:5], 5'(rs2), 5'(rs1), 3'b010, i[4:0], 7'b0100011};
    endfunction
    function automatic logic [31:0] enc_beq(input int rs1, input int rs2, input int off);
        logic [12:0] o = 13'(off);
        return {o[12], o[10:5], 5'(rs2), 5'(rs1), 3'b000, o[4:1], o[11], 7'b1100011};
    endfunction
    function automatic logic [31:0] enc_jal(input int rd, input int off);
        logic [20:0] o = 21'(off);
        return {o[20], o[10:1], o[11], o[19:12], 5'(rd), 7'b1101111};
    endfunction

    task automatic load_word(input bit sel, input int idx, input logic [31:0] w);
        @(negedge clk);
        ld_en = 1'b1; ld_sel = sel; ld_addr = AW'(idx); ld_data = w;
        if (sel) m_dmem[idx] = w; else m_imem[idx] = w;
    endtask

    // Compare the current trace with the model, then step the model.
    task automatic compare_and_step();
        logic [31:0] ins, a, b, ea, nxt, wd, eimm;
        logic [6:0]  opc;
        logic [4:0]  rd;
        bit          we, se;
        string       tag;
        ins = m_imem[m_pc[AW+1:2]];
        opc = ins[6:0];
        rd  = ins[11:7];
        a   = (ins[19:15] == 0) ? 32'd0 : m_reg[ins[19:15]];
        b   = (ins[24:20] == 0) ? 32'd0 : m_reg[ins[24:20]];
        we = 0; se = 0; wd = 0; ea = 0; nxt = m_pc + 4; tag = "R8";
        if (opc == 7'b0110011 && ins[14:12] == 0 && ins[31:25] == 0) begin
            we = 1; wd = a + b; tag = "R2";
        end else if (opc == 7'b0110011 && ins[14:12] == 0 && ins[31:25] == 7'b0100000) begin
            we = 1; wd = a - b; tag = "R2";
        end else if (opc == 7'b0000011 && ins[14:12] == 3'b010) begin
            eimm = {{20{ins[31]}}, ins[31:20]};
            ea = a + eimm; we = 1; wd = m_dmem[ea[AW+1:2]]; tag = "R4/R10";
        end else if (opc == 7'b0100011 && ins[14:12] == 3'b010) begin
            eimm = {{20{ins[31]}}, ins[31:25], ins[11:7]};
            ea = a + eimm; se = 1; tag = "R5";
        end else if (opc == 7'b1100011 && ins[14:12] == 0) begin
            eimm = {{19{ins[31]}}, ins[31], ins[7], ins[30:25], ins[11:8], 1'b0};
            if (a == b) nxt = m_pc + eimm;
            tag = "R6";
        end else if (opc == 7'b1101111) begin
            eimm = {{11{ins[31]}}, ins[31], ins[19:12], ins[20], ins[30:21], 1'b0};
            nxt = m_pc + eimm; we = 1; wd = m_pc + 4; tag = "R7";
        end
        if (we && rd == 0) begin we = 0; tag = "R3"; end
        if (tag == "R2" && (ins[19:15] == 0 || ins[24:20] == 0)) tag = "R3";
        chk(pc_out == m_pc, (tag == "R6" || tag == "R7") ? tag : "R9", "pc", pc_out, m_pc);
        chk(wb_en == we, tag, "wb_en", 32'(wb_en), 32'(we));
        if (we) chk(wb_rd == rd && wb_data == wd, tag, "wb_data", wb_data, wd);
        chk(st_en == se, tag, "st_en", 32'(st_en), 32'(se));
        if (se) chk(st_addr == ea && st_data == b, tag, "st_addr/data", st_data, b);
        if (we) m_reg[rd] = wd;
        if (se) m_dmem[ea[AW+1:2]] = b;
        m_pc = nxt;
    endtask

    // Watchdog: a hung run counts as one failure.
    initial begin
        #(5 * 20000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %h expected %h", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] prog [20];
        foreach (m_reg[k]) m_reg[k] = '0;
        m_pc = '0;
        prog[0]  = enc_lw(1, 0, 0);
        prog[1]  = enc_lw(2, 0, 4);
        prog[2]  = enc_r(7'b0000000, 3, 1, 2);
        prog[3]  = enc_r(7'b0100000, 4, 3, 1);
        prog[4]  = enc_sw(3, 0, 8);
        prog[5]  = enc_lw(5, 0, 8);
        prog[6]  = enc_r(7'b0000000, 0, 1, 2);
        prog[7]  = enc_r(7'b0000000, 6, 0, 1);
        prog[8]  = enc_beq(1, 2, 8);
        prog[9]  = enc_r(7'b0000000, 7, 1, 1);
        prog[10] = enc_beq(1, 3, 8);
        prog[11] = enc_jal(8, 12);
        prog[12] = enc_r(7'b0000000, 11, 1, 1);
        prog[13] = enc_r(7'b0000000, 11, 1, 1);
        prog[14] = 32'hFFFF_FFFF;
        prog[15] = enc_r(7'b0100000, 9, 0, 1);
        prog[16] = enc_sw(9, 2, 7);
        prog[17] = enc_lw(10, 4, 7);
        prog[18] = {7'b0000001, 5'd2, 5'd1, 3'b000, 5'd12, 7'b0110011};
        prog[19] = enc_beq(0, 0, -76);
        for (int k = 0; k < 20; k++) load_word(1'b0, k, prog[k]);
        load_word(1'b1, 0, 32'd5);
        load_word(1'b1, 1, 32'd5);
        @(negedge clk);
        ld_en = 1'b0;
        // R1: PC held at zero during reset, nothing committed.
        chk(pc_out == 0, "R1", "reset pc", pc_out, 0);
        chk(!wb_en && !st_en, "R1", "reset commit", 32'({wb_en, st_en}), 0);
        rst_n = 1'b1;
        for (int c = 0; c < NCYC; c++) begin
            #1;
            if (c == 45) begin
                rst_n = 1'b0;
                #1;
                chk(!wb_en && !st_en, "R1", "mid-run reset commit", 32'({wb_en, st_en}), 0);
                @(negedge clk);
                chk(pc_out == 0, "R1", "mid-run reset pc", pc_out, 0);
                m_pc = '0;
                rst_n = 1'b1;
                #1;
            end
            compare_and_step();
            @(negedge clk);
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule